// File: doc/BRIEF.md
# Vector Memory Address Generator

This block produces the beat-by-beat request stream for one vector load or store. A start pulse captures the operation: the base byte address, a per-element stride or a vector of per-element indices, the vector length, the element size, whether it is a store, and a per-element flag mask. The block then waits two cycles of fixed setup overhead. After that it issues one memory beat per element. Each beat carries a word-aligned address, byte enables, the byte offset that steers the byte crossbar, and the lane and lane group that the element belongs to.

Three addressing modes are supported. In unit-stride mode elements are packed back to back. In constant-stride mode the spacing is a multiple of the element size. In indexed mode each element's offset comes from its own index. Elements may be 8, 16 or 32 bits, and every element of that size is individually addressable inside the memory word. The memory port follows a plain request/grant handshake. A beat is held steady until it is granted, and a one-cycle done pulse marks the end of the operation.

Top module: `vagen_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `req`, `busy`, `done`, `err` are 0 and `be` is all zeros.
- R2: A start accepted while idle gives exactly two cycles with `busy`=1 and `req`=0. The beat for element 0 is presented on the third cycle.
- R3: With `mode`=0 (unit stride), element i has byte address base + i*S. S is the element size in bytes: `esize` 0→1, 1→2, 2→4, and 3 is treated as 2. `addr` is that byte address with its low two bits cleared, and `byte_ofs` holds those two low bits. Addresses wrap modulo 2^16.
- R4: With `mode`=1 (constant stride), element i has byte address base + i*stride*S.
- R5: With `mode`=2 (indexed), element i has byte address base + idx[i]*S. idx[i] is bits [8i+7:8i] of `idx_vec`. `mode`=3 behaves as unit stride.
- R6: For an aligned element, `be` has S consecutive ones starting at bit `byte_ofs`.
- R7: An element whose byte address is not a multiple of S raises `err` for that beat and gives `be`=0.
- R8: While `req`=1 and `gnt`=0, the beat (address, enables, lane) stays unchanged in the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the last element's grant, with `req`=0. A vector length of 0 gives `done` right after the overhead, with no beat. Then `busy` returns to 0.
- R10: For stores, an element whose `mask` bit i is 0 gives `be`=0. Loads ignore `mask`.
- R11: `lane_sel` is i mod 4 and `lane_grp` is i div 4 for element i.
- R12: `start` and all operand inputs are ignored while busy. The running operation uses the values captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_store | input | 1 | 1 = store, applies the flag mask |
| mode | input | 2 | 0 unit, 1 constant stride, 2 indexed |
| esize | input | 2 | Element size code: 0 byte, 1 half, 2 word |
| base | input | 16 | Base byte address |
| stride | input | 8 | Stride in elements (unsigned) |
| vl | input | 5 | Vector length, clamped to 16 |
| idx_vec | input | 128 | Per-element indices, 8 bits each |
| mask | input | 16 | Per-element store flags |
| gnt | input | 1 | Memory grant for the current beat |
| req | output | 1 | Beat valid |
| addr | output | 16 | Word-aligned beat address |
| be | output | 4 | Byte enables |
| byte_ofs | output | 2 | Byte offset of the element for the crossbar |
| lane_sel | output | 2 | Destination or source lane of the element |
| lane_grp | output | 2 | Lane group of the element |
| err | output | 1 | Current element is misaligned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The assertions assume that `gnt` is only meaningful while `req` is high and that reset is applied before the first start. The bench raises `gnt` on a pseudo-random pattern and always lets the operation finish. The checks assume `vl` stays within 16. The sweep covers every mode, every element size, aligned and misaligned bases, a wrapping base, and both loads and stores, with vector lengths of 0, 5 and 16. In some operations the bench keeps `start` high and scrambles the operands while the block is busy.

// File: rtl/vagen_pkg.sv
package vagen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE1  = 3'd1,
    ST_PRE2  = 3'd2,
    ST_ISSUE = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  localparam logic [1:0] MODE_UNIT   = 2'd0;
  localparam logic [1:0] MODE_STRIDE = 2'd1;
  localparam logic [1:0] MODE_INDEX  = 2'd2;
endpackage

// File: rtl/vagen_seq.sv
module vagen_seq
  import vagen_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int EW     = $clog2(MAX_VL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [VL_W-1:0] vl,
  input  logic          gnt,
  output logic          load,
  output logic [EW-1:0] elem,
  output logic          req,
  output logic          busy,
  output logic          done
);
  seq_state_t state;
  logic [VL_W-1:0] vl_q;

  assign load = start && (state == ST_IDLE);
  assign req  = (state == ST_ISSUE);
  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      vl_q  <= '0;
      elem  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          vl_q  <= (vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl;
          elem  <= '0;
          state <= ST_PRE1;
        end
        ST_PRE1: state <= ST_PRE2;
        ST_PRE2: state <= (vl_q == '0) ? ST_DONE : ST_ISSUE;
        ST_ISSUE: if (gnt) begin
          if (VL_W'(elem) == vl_q - VL_W'(1)) state <= ST_DONE;
          else elem <= elem + EW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vagen_addr.sv
module vagen_addr
  import vagen_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int STRIDE_W  = 8,
  parameter int IDX_W     = 8,
  parameter int MAX_VL    = 16,
  parameter int NLANE     = 4,
  parameter int MEM_BYTES = 4,
  parameter int EW        = $clog2(MAX_VL),
  parameter int OFS_W     = $clog2(MEM_BYTES),
  parameter int LANE_W    = $clog2(NLANE),
  parameter int GRP_W     = EW - LANE_W
) (
  input  logic                    active,
  input  logic [1:0]              mode_q,
  input  logic [1:0]              es_q,
  input  logic                    store_q,
  input  logic [ADDR_W-1:0]       base_q,
  input  logic [STRIDE_W-1:0]     stride_q,
  input  logic [MAX_VL*IDX_W-1:0] idx_q,
  input  logic [MAX_VL-1:0]       mask_q,
  input  logic [EW-1:0]           elem,
  output logic [ADDR_W-1:0]       addr,
  output logic [MEM_BYTES-1:0]    be,
  output logic [OFS_W-1:0]        byte_ofs,
  output logic [LANE_W-1:0]       lane_sel,
  output logic [GRP_W-1:0]        lane_grp,
  output logic                    err
);
  localparam int MUL_W = EW + STRIDE_W;

  logic [MUL_W-1:0]     prod;
  logic [ADDR_W-1:0]    elem_off;
  logic [ADDR_W-1:0]    byte_addr;
  logic [OFS_W-1:0]     size_mask;
  logic [MEM_BYTES-1:0] be_raw;
  logic                 misal;

  always_comb begin
    prod = MUL_W'(elem) * MUL_W'(stride_q);
    case (mode_q)
      MODE_STRIDE: elem_off = ADDR_W'(prod);
      MODE_INDEX:  elem_off = ADDR_W'(idx_q[elem*IDX_W +: IDX_W]);
      default:     elem_off = ADDR_W'(elem);
    endcase
    byte_addr = base_q + (elem_off << es_q);
    size_mask = OFS_W'((32'd1 << es_q) - 32'd1);
    misal     = (byte_addr[OFS_W-1:0] & size_mask) != '0;
    be_raw    = MEM_BYTES'((32'd1 << (32'd1 << es_q)) - 32'd1) << byte_addr[OFS_W-1:0];
  end

  assign addr     = {byte_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign byte_ofs = byte_addr[OFS_W-1:0];
  assign lane_sel = elem[LANE_W-1:0];
  assign lane_grp = elem[EW-1:LANE_W];
  assign err      = active && misal;
  assign be       = (!active || misal || (store_q && !mask_q[elem])) ? '0 : be_raw;
endmodule

// File: rtl/vagen_top.sv
module vagen_top
  import vagen_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int STRIDE_W  = 8,
  parameter int IDX_W     = 8,
  parameter int MAX_VL    = 16,
  parameter int NLANE     = 4,
  parameter int MEM_BYTES = 4,
  parameter int VL_W      = $clog2(MAX_VL + 1),
  parameter int EW        = $clog2(MAX_VL),
  parameter int OFS_W     = $clog2(MEM_BYTES),
  parameter int LANE_W    = $clog2(NLANE),
  parameter int GRP_W     = EW - LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    is_store,
  input  logic [1:0]              mode,
  input  logic [1:0]              esize,
  input  logic [ADDR_W-1:0]       base,
  input  logic [STRIDE_W-1:0]     stride,
  input  logic [VL_W-1:0]         vl,
  input  logic [MAX_VL*IDX_W-1:0] idx_vec,
  input  logic [MAX_VL-1:0]       mask,
  input  logic                    gnt,
  output logic                    req,
  output logic [ADDR_W-1:0]       addr,
  output logic [MEM_BYTES-1:0]    be,
  output logic [OFS_W-1:0]        byte_ofs,
  output logic [LANE_W-1:0]       lane_sel,
  output logic [GRP_W-1:0]        lane_grp,
  output logic                    err,
  output logic                    busy,
  output logic                    done
);
  logic                    load;
  logic [EW-1:0]           elem;
  logic [1:0]              mode_q, es_q;
  logic                    store_q;
  logic [ADDR_W-1:0]       base_q;
  logic [STRIDE_W-1:0]     stride_q;
  logic [MAX_VL*IDX_W-1:0] idx_q;
  logic [MAX_VL-1:0]       mask_q;

  // operand capture; size code 3 folds onto the word size
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; es_q <= '0; store_q <= 1'b0; base_q <= '0;
      stride_q <= '0; idx_q <= '0; mask_q <= '0;
    end else if (load) begin
      mode_q   <= mode;
      es_q     <= (esize == 2'd3) ? 2'd2 : esize;
      store_q  <= is_store;
      base_q   <= base;
      stride_q <= stride;
      idx_q    <= idx_vec;
      mask_q   <= mask;
    end
  end

  vagen_seq #(.MAX_VL(MAX_VL), .VL_W(VL_W), .EW(EW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .gnt(gnt),
    .load(load), .elem(elem), .req(req), .busy(busy), .done(done)
  );

  vagen_addr #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .IDX_W(IDX_W), .MAX_VL(MAX_VL),
    .NLANE(NLANE), .MEM_BYTES(MEM_BYTES), .EW(EW), .OFS_W(OFS_W),
    .LANE_W(LANE_W), .GRP_W(GRP_W)
  ) u_addr (
    .active(req), .mode_q(mode_q), .es_q(es_q), .store_q(store_q),
    .base_q(base_q), .stride_q(stride_q), .idx_q(idx_q), .mask_q(mask_q),
    .elem(elem), .addr(addr), .be(be), .byte_ofs(byte_ofs),
    .lane_sel(lane_sel), .lane_grp(lane_grp), .err(err)
  );
endmodule

// File: rtl/vagen_chk.sv
module vagen_chk #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req,
  input logic                 gnt,
  input logic [ADDR_W-1:0]    addr,
  input logic [MEM_BYTES-1:0] be,
  input logic                 err,
  input logic                 busy,
  input logic                 done
);
  // R8
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    req && !gnt |=> req && $stable(addr) && $stable(be));
  // R9
  done_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !req);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);
  // R7
  err_no_be_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> be == '0);
  // R2
  setup_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !req ##1 !req);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req |-> be == '0 && !err);
endmodule

bind vagen_top vagen_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_chk (
  .clk(clk), .rst(rst), .req(req), .gnt(gnt), .addr(addr), .be(be),
  .err(err), .busy(busy), .done(done)
);

// File: tb/vagen_top_tb.sv
module vagen_top_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0, rst = 1'b1, start = 1'b0, is_store = 1'b0, gnt = 1'b0;
  logic [1:0]   mode = '0, esize = '0;
  logic [15:0]  base = '0;
  logic [7:0]   stride = '0;
  logic [4:0]   vl = '0;
  logic [127:0] idx_vec = '0;
  logic [15:0]  mask = '0;
  logic         req, err, busy, done;
  logic [15:0]  addr;
  logic [3:0]   be;
  logic [1:0]   byte_ofs, lane_sel, lane_grp;

  int n_tests = 0, n_fail = 0;
  logic [7:0] lfsr = 8'h5A;

  vagen_top u_dut (
    .clk(clk), .rst(rst), .start(start), .is_store(is_store), .mode(mode),
    .esize(esize), .base(base), .stride(stride), .vl(vl), .idx_vec(idx_vec),
    .mask(mask), .gnt(gnt), .req(req), .addr(addr), .be(be),
    .byte_ofs(byte_ofs), .lane_sel(lane_sel), .lane_grp(lane_grp),
    .err(err), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int md, input int es, input int b, input int st,
                        input int len, input bit store, input bit poke);
    int sz, k, ba, off, exp_be;
    bit mis;
    sz = 1 << ((es == 3) ? 2 : es);
    @(negedge clk);
    mode = 2'(md); esize = 2'(es); base = 16'(b); stride = 8'(st); vl = 5'(len);
    is_store = store; start = 1'b1; gnt = 1'b0;
    @(negedge clk);
    chk(busy && !req, "R2 setup cycle 1 busy/req", {busy, req}, 2);
    if (poke) begin
      base = ~base; mode = 2'(md + 1); esize = 2'(es + 1); stride = 8'hFF;
      idx_vec = ~idx_vec; mask = ~mask; is_store = ~is_store; vl = 5'd3;
    end else start = 1'b0;
    @(negedge clk);
    chk(busy && !req, "R2 setup cycle 2 busy/req", {busy, req}, 2);
    k = 0;
    while (k < len) begin
      @(negedge clk);
      if (md == 2) off = (k * 7 + 3) & 8'hFF;   // bench's original index pattern
      else if (md == 1) off = k * st;
      else off = k;
      ba = (b + off * sz) & 16'hFFFF;
      mis = (ba % sz) != 0;
      exp_be = (mis || (store && !(((16'hA5C3) >> k) & 1))) ? 0 : (((1 << sz) - 1) << (ba & 3));
      chk(req, "R2/R8 beat present", req, 1);
      chk(addr == 16'(ba & 16'hFFFC) && byte_ofs == 2'(ba & 3),
          md == 2 ? (poke ? "R5/R12 addr" : "R5 addr") : md == 1 ? (poke ? "R4/R12 addr" : "R4 addr") : (poke ? "R3/R12 addr" : "R3 addr"),
          {addr, 14'd0, byte_ofs}, ((ba & 16'hFFFC) << 16) | (ba & 3));
      chk(be == 4'(exp_be) && err == mis,
          mis ? "R7 misaligned" : (store ? "R6/R10 be" : "R6 be"),
          {be, 3'd0, err}, (exp_be << 4) | int'(mis));
      chk(lane_sel == 2'(k % 4) && lane_grp == 2'(k / 4), "R11 lane",
          {lane_sel, lane_grp}, ((k % 4) << 2) | (k / 4));
      gnt = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (gnt) k++;
    end
    @(negedge clk);
    gnt = 1'b0; start = 1'b0;
    chk(done && !req, "R9 done after last beat", {done, req}, 2);
    @(negedge clk);
    chk(!done && !busy, "R9 single done pulse", {done, busy}, 0);
    idx_vec = '0;
    for (int i = 0; i < 16; i++) idx_vec[i*8 +: 8] = 8'((i * 7 + 3) & 8'hFF);
    mask = 16'hA5C3;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) idx_vec[i*8 +: 8] = 8'((i * 7 + 3) & 8'hFF);
    mask = 16'hA5C3;
    repeat (3) @(negedge clk);
    chk(!req && !busy && !done && !err && be == 0, "R1 in reset", {req, busy, done, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!req && !busy && !done && !err && be == 0, "R1 after reset", {req, busy, done, err}, 0);
    for (int md = 0; md < 4; md++)
      for (int es = 0; es < 4; es++)
        for (int bi = 0; bi < 4; bi++)
          for (int s = 0; s < 2; s++)
            for (int li = 0; li < 3; li++) begin
              int bases[4] = '{16'h1000, 16'h1001, 16'h2002, 16'hFFF0};
              int lens[3]  = '{0, 5, 16};
              run_op(md == 3 ? 0 : md, es, bases[bi], 3 + bi, lens[li], s[0],
                     bi == 1 && li == 1);
            end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule